// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block lets on-chip logic read and write 16-bit words in a small three-wire serial EEPROM that holds 64 words. The host raises a one-cycle request with a direction flag, a 6-bit word address and, for writes, a data word. The block then runs every serial frame the transfer needs. When it finishes it pulses a done strobe and presents the read word and an error flag.

Every frame opens the same way. Chip select is held low for one phase. Chip select then rises, and one clock is sent with data-in at 0 before the start bit. Each bit is a three-phase pulse: clock low, clock high, clock low. A phase lasts `CLK_DIV` system clocks, so a slow device can be matched by setting that divider.

A write always runs as three steps in order:
- a write-enable frame,
- the write frame itself,
- a ready poll that samples the device's data-out every `POLL_GAP` clocks for at most `POLL_TRIES` attempts.

If the device never reports ready, the write ends with the error flag set.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While reset is asserted, and after it is released, `ee_cs`, `ee_sk`, `ee_di`, `rsp_done`, `rsp_err` and `rsp_rdata` are all 0.
- R2: Each frame has the following order:
  - `ee_cs` low for at least `CLK_DIV` clocks;
  - `ee_cs` high;
  - a first clocked bit of 0;
  - a start bit of 1.
- R3: A read frame is the start bit 1, opcode 1 then 0, and the 6 address bits MSB first. It is followed by 16 clocks in which `ee_do` is sampled while `ee_sk` is high. These samples, MSB first, become `rsp_rdata`, and `ee_cs` falls after the 16th.
- R4: A write sends two frames, with `ee_cs` low between them:
  - a write-enable frame: start bit 1, opcode 0,0, six 1 bits;
  - then a write frame: start bit 1, opcode 0,1, address MSB first, 16 data bits MSB first.
  The device accepts a write only directly after an enable, so a missing enable loses the data.
- R5: `ee_sk` is high only while `ee_cs` is high, and `ee_di` does not change while `ee_sk` is high.
- R6: Every level of `ee_sk` lasts at least `CLK_DIV` system clocks.
- R7: After the write frame, `ee_cs` goes low for one phase and then high again. `ee_do` is then sampled once per `POLL_GAP` clocks. `rsp_done` comes only after a sample of 1, with `rsp_err` = 0.
- R8: If `POLL_TRIES` samples in a row read 0, the write ends with `rsp_done` and `rsp_err` = 1. This happens no earlier than `POLL_TRIES*POLL_GAP` clocks after acceptance.
- R9: A request is accepted only while idle, and a request present in the cycle of `rsp_done` is ignored. `rsp_done` lasts exactly one cycle. `rsp_rdata` holds its value from `rsp_done` until the next request is accepted.
- R10: `rsp_err` returns to 0 in the cycle after a request is accepted. A read never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Word to write |
| rsp_rdata | output | DATA_W | Last word read |
| rsp_done | output | 1 | One-cycle end-of-transfer strobe |
| rsp_err | output | 1 | Write ready-poll timed out |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
Two events can fall in one cycle: the end-of-transfer strobe and a host request. The bench provokes this by holding `req` high through a whole read. In the cycle where `rsp_done` appears, it changes the address while `req` stays high. The bench's device model must see exactly two read frames, and the second must carry the new address. The returned words must match the model's contents for each address. `rsp_rdata` must not move in the idle cycles between.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CSOFF,
    S_SHIFT,
    S_POLL,
    S_END,
    S_FIN
  } ctl_state_t;

  typedef enum logic [1:0] {
    STG_WEN,
    STG_WR,
    STG_RD,
    STG_POLL
  } stage_t;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_EWEN  = 2'b00;
  localparam logic       LEAD_BIT  = 1'b0;
  localparam logic       START_BIT = 1'b1;
endpackage

// File: rtl/uwire_rst_sync.sv
module uwire_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/uwire_phase_timer.sv
module uwire_phase_timer #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (!en)                cnt_nx = '0;
    else if (cnt_q == LAST) cnt_nx = '0;
    else                    cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/uwire_shifter.sv
module uwire_shifter #(
  parameter int FR_W = 26,
  parameter int RX_W = 16,
  parameter int DIV  = 50,
  parameter int NB_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [FR_W-1:0] frame,
  input  logic [NB_W-1:0] nbits,
  input  logic            sdo,
  output logic            sk,
  output logic            sdi,
  output logic            fin,
  output logic [RX_W-1:0] rx
);
  logic [FR_W-1:0] sh_q, sh_nx;
  logic [NB_W-1:0] left_q, left_nx;
  logic [1:0]      ph_q, ph_nx;
  logic            act_q, act_nx;
  logic [RX_W-1:0] rx_q, rx_nx;
  logic            tick;

  uwire_phase_timer #(.DIV(DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (act_q),
    .tick (tick)
  );

  always_comb begin
    sh_nx   = sh_q;
    left_nx = left_q;
    ph_nx   = ph_q;
    act_nx  = act_q;
    rx_nx   = rx_q;
    fin     = 1'b0;
    if (start) begin
      sh_nx   = frame;
      left_nx = nbits;
      ph_nx   = 2'd0;
      act_nx  = 1'b1;
    end else if (act_q && tick) begin
      case (ph_q)
        2'd0: ph_nx = 2'd1;
        2'd1: begin
          ph_nx = 2'd2;
          rx_nx = {rx_q[RX_W-2:0], sdo};
        end
        2'd2: begin
          ph_nx   = 2'd0;
          sh_nx   = {sh_q[FR_W-2:0], 1'b0};
          left_nx = left_q - 1'b1;
          if (left_q == NB_W'(1)) begin
            act_nx = 1'b0;
            fin    = 1'b1;
          end
        end
        default: ph_nx = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      ph_q   <= 2'd0;
      act_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      sh_q   <= sh_nx;
      left_q <= left_nx;
      ph_q   <= ph_nx;
      act_q  <= act_nx;
      rx_q   <= rx_nx;
    end
  end

  assign sk  = act_q && (ph_q == 2'd1);
  assign sdi = act_q && sh_q[FR_W-1];
  assign rx  = rx_q;
endmodule

// File: rtl/uwire_ready_poll.sv
module uwire_ready_poll #(
  parameter int GAP   = 50000,
  parameter int TRIES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sdo,
  output logic fin,
  output logic timeout
);
  localparam int GW = $clog2(GAP + 1);
  localparam int TW = $clog2(TRIES + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(TRIES - 1);

  logic          act_q, act_nx;
  logic [GW-1:0] gap_q, gap_nx;
  logic [TW-1:0] try_q, try_nx;
  logic          gap_end;

  assign gap_end = act_q && (gap_q == GAP_LAST);
  assign fin     = gap_end && (sdo || (try_q == TRY_LAST));
  assign timeout = fin && !sdo;

  always_comb begin
    act_nx = act_q;
    gap_nx = gap_q;
    try_nx = try_q;
    if (start) begin
      act_nx = 1'b1;
      gap_nx = '0;
      try_nx = '0;
    end else if (act_q) begin
      if (gap_end) begin
        gap_nx = '0;
        if (fin) act_nx = 1'b0;
        else     try_nx = try_q + 1'b1;
      end else begin
        gap_nx = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      gap_q <= '0;
      try_q <= '0;
    end else begin
      act_q <= act_nx;
      gap_q <= gap_nx;
      try_q <= try_nx;
    end
  end
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CLK_DIV    = 50,
  parameter int POLL_GAP   = 50000,
  parameter int POLL_TRIES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int HDR_W = 4 + ADDR_W;
  localparam int FR_W  = HDR_W + DATA_W;
  localparam int NB_W  = $clog2(FR_W + 1);

  logic              rst_n_s;
  ctl_state_t        state_q, state_nx;
  stage_t            stage_q, stage_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx;
  logic [DATA_W-1:0] data_q, data_nx;
  logic [DATA_W-1:0] rdata_q, rdata_nx;
  logic              err_q, err_nx;
  logic              tmo_q, tmo_nx;

  logic              cs_tick;
  logic              sh_start, sh_fin, sh_sk, sh_di;
  logic [DATA_W-1:0] sh_rx;
  logic [FR_W-1:0]   frame;
  logic [NB_W-1:0]   nbits;
  logic              poll_start, poll_fin, poll_to;

  uwire_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  uwire_phase_timer #(.DIV(CLK_DIV)) u_cs_timer (
    .clk  (clk),
    .rst_n(rst_n_s),
    .en   ((state_q == S_CSOFF) || (state_q == S_END)),
    .tick (cs_tick)
  );

  // frame contents per stage, left aligned, lead zero first
  always_comb begin
    case (stage_q)
      STG_WEN: begin
        frame = {LEAD_BIT, START_BIT, OPC_EWEN, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
        nbits = NB_W'(HDR_W);
      end
      STG_WR: begin
        frame = {LEAD_BIT, START_BIT, OPC_WRITE, addr_q, data_q};
        nbits = NB_W'(FR_W);
      end
      default: begin
        frame = {LEAD_BIT, START_BIT, OPC_READ, addr_q, {DATA_W{1'b0}}};
        nbits = NB_W'(FR_W);
      end
    endcase
  end

  assign sh_start   = (state_q == S_CSOFF) && cs_tick && (stage_q != STG_POLL);
  assign poll_start = (state_q == S_CSOFF) && cs_tick && (stage_q == STG_POLL);

  uwire_shifter #(
    .FR_W(FR_W),
    .RX_W(DATA_W),
    .DIV (CLK_DIV),
    .NB_W(NB_W)
  ) u_shifter (
    .clk  (clk),
    .rst_n(rst_n_s),
    .start(sh_start),
    .frame(frame),
    .nbits(nbits),
    .sdo  (ee_do),
    .sk   (sh_sk),
    .sdi  (sh_di),
    .fin  (sh_fin),
    .rx   (sh_rx)
  );

  uwire_ready_poll #(
    .GAP  (POLL_GAP),
    .TRIES(POLL_TRIES)
  ) u_poll (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (poll_start),
    .sdo    (ee_do),
    .fin    (poll_fin),
    .timeout(poll_to)
  );

  always_comb begin
    state_nx = state_q;
    stage_nx = stage_q;
    addr_nx  = addr_q;
    data_nx  = data_q;
    rdata_nx = rdata_q;
    err_nx   = err_q;
    tmo_nx   = tmo_q;
    case (state_q)
      S_IDLE: if (req) begin
        state_nx = S_CSOFF;
        stage_nx = req_write ? STG_WEN : STG_RD;
        addr_nx  = req_addr;
        data_nx  = req_wdata;
        err_nx   = 1'b0;
        tmo_nx   = 1'b0;
      end
      S_CSOFF: if (cs_tick) state_nx = (stage_q == STG_POLL) ? S_POLL : S_SHIFT;
      S_SHIFT: if (sh_fin) begin
        case (stage_q)
          STG_WEN: begin
            stage_nx = STG_WR;
            state_nx = S_CSOFF;
          end
          STG_WR: begin
            stage_nx = STG_POLL;
            state_nx = S_CSOFF;
          end
          default: begin
            rdata_nx = sh_rx;
            state_nx = S_END;
          end
        endcase
      end
      S_POLL: if (poll_fin) begin
        tmo_nx   = poll_to;
        state_nx = S_END;
      end
      S_END: if (cs_tick) begin
        err_nx   = tmo_q;
        state_nx = S_FIN;
      end
      S_FIN:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      stage_q <= STG_RD;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_nx;
      stage_q <= stage_nx;
      addr_q  <= addr_nx;
      data_q  <= data_nx;
      rdata_q <= rdata_nx;
      err_q   <= err_nx;
      tmo_q   <= tmo_nx;
    end
  end

  assign ee_cs     = (state_q == S_SHIFT) || (state_q == S_POLL);
  assign ee_sk     = sh_sk;
  assign ee_di     = sh_di;
  assign rsp_done  = (state_q == S_FIN);
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/uwire_eeprom_master_chk.sv
module uwire_eeprom_master_chk #(
  parameter int CLK_DIV = 50
) (
  input logic clk,
  input logic rst_n,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic rsp_done,
  input logic rsp_err
);
  logic        sk_q;
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q  <= 1'b0;
      run_q <= '0;
    end else begin
      sk_q <= ee_sk;
      if (ee_sk != sk_q)               run_q <= 32'd1;
      else if (run_q < 32'(CLK_DIV))   run_q <= run_q + 32'd1;
    end
  end

  assert_sk_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_di_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  assert_phase_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk != sk_q) |-> (run_q >= 32'(CLK_DIV)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err) |-> rsp_done);

  assert_cs_off_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !ee_cs);
endmodule

bind uwire_eeprom_master uwire_eeprom_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ee_cs   (ee_cs),
  .ee_sk   (ee_sk),
  .ee_di   (ee_di),
  .rsp_done(rsp_done),
  .rsp_err (rsp_err)
);

// File: tb/uwire_eeprom_master_tb.sv
module uwire_eeprom_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 3;
  localparam int GAP   = 20;
  localparam int TRIES = 100;
  localparam int BUSY  = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_write;
  logic [5:0]  req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rsp_rdata;
  logic        rsp_done, rsp_err, ee_cs, ee_sk, ee_di, ee_do;

  always #(CLK_PERIOD/2) clk = ~clk;

  uwire_eeprom_master #(
    .ADDR_W(6), .DATA_W(16), .CLK_DIV(DIV), .POLL_GAP(GAP), .POLL_TRIES(TRIES)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  function automatic int pat(input int a);
    return ((a * 16'h0413) ^ 16'hA5C3) & 16'hFFFF;
  endfunction

  // ---------------- behavioural device model ----------------
  int  cyc = 0;
  bit  stuck = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          written [64];
  int          wval    [64];
  int          frame_log [256];
  int          log_n = 0;
  int          lead_bad = 0;
  int          ignored = 0;
  int          busy_until = 0;
  bit          started = 0, first_bit = 0, wen = 0, sk_p = 0, cs_p = 0, do_r = 0;
  int          nb = 0, op = 0, adr = 0, dat = 0;

  always @(ee_sk or ee_cs) begin
    if (ee_cs && !cs_p) begin
      started = 0; first_bit = 1; nb = 0; op = 0;
    end
    if (!ee_cs && cs_p && started) begin
      if (op == 0 && nb == 8 && adr[5:4] == 2'b11) begin
        wen = 1; frame_log[log_n % 256] = 0; log_n = log_n + 1;
      end else if (op == 1 && nb == 24) begin
        frame_log[log_n % 256] = 1; log_n = log_n + 1;
        if (wen) begin
          written[adr] = 1; wval[adr] = dat; busy_until = cyc + BUSY;
        end else ignored = ignored + 1;
        wen = 0;
      end else if (op == 2 && nb == 24) begin
        frame_log[log_n % 256] = 2; log_n = log_n + 1;
      end else begin
        frame_log[log_n % 256] = 9; log_n = log_n + 1;
      end
      started = 0;
    end
    if (ee_sk && !sk_p && ee_cs) begin
      if (first_bit) begin
        first_bit = 0;
        if (ee_di !== 1'b0) lead_bad = lead_bad + 1;
      end
      if (!started) begin
        if (ee_di) begin started = 1; nb = 0; op = 0; adr = 0; dat = 0; end
      end else begin
        nb = nb + 1;
        if (nb <= 2)       op  = ((op << 1) | int'(ee_di)) & 3;
        else if (nb <= 8)  adr = ((adr << 1) | int'(ee_di)) & 63;
        else if (nb <= 24) dat = ((dat << 1) | int'(ee_di)) & 16'hFFFF;
      end
    end
    if (!ee_sk && sk_p && ee_cs && started && op == 2 && nb >= 8 && nb <= 23) begin
      int v;
      v = written[adr] ? wval[adr] : pat(adr);
      do_r = v[23 - nb];
    end
    sk_p = ee_sk;
    cs_p = ee_cs;
  end

  wire model_busy = stuck || (cyc < busy_until);
  assign ee_do = ee_cs ? (started ? do_r : !model_busy) : 1'b0;

  // ---------------- per-clock comparison ----------------
  int vectors = 0, fails = 0;
  int mon_vec = 0, mon_fail = 0, done_cnt = 0;
  int hi_run = 0, min_hi = 1000000, lo_run = 0;
  bit mon_en = 0, idle_win = 0, cs_prev = 0;
  logic [15:0] last_rd = 16'h0;

  always @(negedge clk) begin
    if (mon_en) begin
      mon_vec = mon_vec + 1;
      if (ee_sk && !ee_cs) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R5 sk=%0b with cs=%0b (expected cs=1)", ee_sk, ee_cs);
      end
      if (idle_win && rsp_rdata !== last_rd) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R9 rdata moved while idle: %h expected %h", rsp_rdata, last_rd);
      end
      if (ee_cs && !cs_prev && lo_run < DIV) begin
        mon_fail = mon_fail + 1;
        $display("FAIL R2 cs low for %0d cycles, expected >= %0d", lo_run, DIV);
      end
      if (rsp_done) done_cnt = done_cnt + 1;
      if (ee_sk) hi_run = hi_run + 1;
      else if (hi_run > 0) begin
        if (hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
      lo_run = ee_cs ? 0 : lo_run + 1;
    end
    cs_prev = ee_cs;
    last_rd = rsp_rdata;
  end

  // ---------------- stimulus ----------------
  task automatic chk(input string tag, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int txns = 0, log_rd = 0;

  task automatic next_frame(input string tag, input int exp);
    chk(tag, (log_rd < log_n) ? frame_log[log_rd % 256] : -1, exp);
    log_rd = log_rd + 1;
  endtask

  task automatic run_txn(input bit wr, input int a, input int d,
                         output int rd, output bit e, output int cyc_n);
    @(negedge clk);
    idle_win = 0; req = 1; req_write = wr; req_addr = 6'(a); req_wdata = 16'(d);
    @(negedge clk);
    req = 0; txns = txns + 1;
    chk("R10 err cleared on accept", int'(rsp_err), 0);
    cyc_n = 1;
    while (!rsp_done) begin
      @(negedge clk);
      cyc_n = cyc_n + 1;
    end
    rd = int'(rsp_rdata); e = rsp_err; idle_win = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired (expected run to finish)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec + 1, fails + mon_fail + 1);
    $finish;
  end

  initial begin
    int rd, n, r1, r2;
    bit e;
    rst_n = 0; req = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 cs", int'(ee_cs), 0); chk("R1 sk", int'(ee_sk), 0);
    chk("R1 di", int'(ee_di), 0); chk("R1 done", int'(rsp_done), 0);
    chk("R1 err", int'(rsp_err), 0); chk("R1 rdata", int'(rsp_rdata), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'({ee_cs, ee_sk, rsp_done, rsp_err}), 0);
    mon_en = 1;

    // R3 reads at both ends and middle of the address range
    run_txn(0, 0, 0, rd, e, n);  chk("R3 read a0", rd, pat(0));  chk("R10 read err", int'(e), 0);
    next_frame("R3 read frame", 2);
    run_txn(0, 63, 0, rd, e, n); chk("R3 read a63", rd, pat(63)); next_frame("R3 read frame", 2);
    run_txn(0, 42, 0, rd, e, n); chk("R3 read a42", rd, pat(42)); next_frame("R3 read frame", 2);

    // R4 / R7 write then read back
    run_txn(1, 5, 16'hBEEF, rd, e, n);
    chk("R7 write err", int'(e), 0);
    chk("R7 done only once ready", int'(model_busy), 0);
    chk("R7 write waited for busy", int'(n > BUSY), 1);
    next_frame("R4 enable first", 0); next_frame("R4 write second", 1);
    run_txn(0, 5, 0, rd, e, n); chk("R4 readback a5", rd, 16'hBEEF); next_frame("R3 read frame", 2);
    run_txn(1, 63, 16'h0001, rd, e, n); chk("R7 write err a63", int'(e), 0);
    next_frame("R4 enable first", 0); next_frame("R4 write second", 1);
    run_txn(1, 0, 16'h8000, rd, e, n);
    next_frame("R4 enable first", 0); next_frame("R4 write second", 1);
    run_txn(0, 63, 0, rd, e, n); chk("R4 readback a63", rd, 16'h0001); next_frame("R3 read frame", 2);
    run_txn(0, 0, 0, rd, e, n);  chk("R4 readback a0", rd, 16'h8000);  next_frame("R3 read frame", 2);

    // R8 timeout
    stuck = 1;
    run_txn(1, 10, 16'h1234, rd, e, n);
    chk("R8 timeout err", int'(e), 1);
    chk("R8 timeout duration", int'(n >= TRIES * GAP), 1);
    next_frame("R4 enable first", 0); next_frame("R4 write second", 1);
    stuck = 0;
    repeat (5) @(negedge clk);
    chk("R8 err held while idle", int'(rsp_err), 1);
    run_txn(0, 11, 0, rd, e, n);
    chk("R10 err after read", int'(e), 0); chk("R3 read a11", rd, pat(11));
    next_frame("R3 read frame", 2);

    // R9 request held across done
    @(negedge clk);
    idle_win = 0; req = 1; req_write = 0; req_addr = 6'd20;
    @(negedge clk);
    while (!rsp_done) @(negedge clk);
    r1 = int'(rsp_rdata); req_addr = 6'd21;
    @(negedge clk);
    @(negedge clk);
    req = 0; txns = txns + 2;
    while (!rsp_done) @(negedge clk);
    r2 = int'(rsp_rdata); idle_win = 1;
    chk("R9 first held read", r1, pat(20));
    chk("R9 second held read", r2, pat(21));
    next_frame("R9 frame one", 2); next_frame("R9 frame two", 2);
    repeat (40) @(negedge clk);
    chk("R9 no extra frames", log_n, log_rd);
    chk("R9 one done per transfer", done_cnt, txns);

    chk("R2 lead zero bit", lead_bad, 0);
    chk("R4 writes without enable", ignored, 0);
    chk("R6 min sk high", int'(min_hi >= DIV), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec, fails + mon_fail);
    $finish;
  end
endmodule